// File: doc/BRIEF.md
# Three-State Snooping Line Coherence Controller

This block holds the coherence state of every line of one direct-mapped write-back cache on a shared snooping bus. Each line is Invalid, Shared (read-only) or Exclusive (read/write). The controller answers local CPU reads and writes with a hit or a miss. On a miss it names the bus request the cache must issue. It also watches the read-miss and write-miss requests that other caches put on the bus, and reports when the local copy must be written back before another cache may use the block.

Each CPU access and each snooped request is handled in the cycle it is presented. The outputs are combinational from the inputs and the stored tag and state. The updated state is registered at the next rising clock edge, and every bus operation is treated as atomic. The address splits into a tag (upper bits) and a line index (lower IDX_W bits). Only the tag and state array lives here. The data array and bus arbitration belong to the surrounding cache.

Top module: `snoop_inval_ctrl`

## Requirements
- R1: After an active-low reset every line is Invalid (state code 2'b00), so the first access to any address is a miss and requests no victim write-back.
- R2: A CPU read that misses drives bus_op_o to the read-miss code 2'b01 with bus_addr_o equal to the CPU address, and the line becomes Shared (code 2'b01), so an immediate re-read hits.
- R3: A CPU write to a line that is Invalid, or held Shared with a matching tag, drives bus_op_o to the write-miss code 2'b10 and leaves the line Exclusive (code 2'b10).
- R4: A read hit on a Shared line, and a read or write hit on an Exclusive line, assert cpu_hit_o, keep bus_op_o at 2'b00, and change no state.
- R5: A snooped write miss (snp_op_i 2'b10) matching a Shared line makes the line Invalid and requests no write-back.
- R6: A snooped read miss (snp_op_i 2'b01) matching an Exclusive line asserts snp_wb_o in that cycle and leaves the line Shared.
- R7: A snooped write miss matching an Exclusive line asserts snp_wb_o in that cycle and leaves the line Invalid.
- R8: A CPU miss whose index holds an Exclusive line with a different tag asserts vic_wb_o with vic_addr_o set to the old tag and the index. A Shared or Invalid victim gives no write-back.
- R9: When a snoop and a CPU access target the same index in one cycle, the snoop is applied first and the CPU access is judged against the state the snoop leaves behind.
- R10: A snoop with snp_op_i 2'b00, a tag mismatch or an Invalid line, or a snooped read miss on a Shared line, changes no state and asserts no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access valid |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | ADDR_W | CPU line address |
| cpu_hit_o | output | 1 | Access served without bus traffic |
| cpu_miss_o | output | 1 | Access needs a bus request |
| bus_op_o | output | 2 | Request to issue: 00 none, 01 read miss, 10 write miss |
| bus_addr_o | output | ADDR_W | Address of the issued request |
| vic_wb_o | output | 1 | Replaced Exclusive line must be written back |
| vic_addr_o | output | ADDR_W | Address of the replaced line |
| snp_valid_i | input | 1 | Snooped bus request valid |
| snp_op_i | input | 2 | Snooped request: 01 read miss, 10 write miss |
| snp_addr_i | input | ADDR_W | Snooped line address |
| snp_wb_o | output | 1 | Local Exclusive copy must be written back for the snoop |

## Verification
The hardest case to reach is a snoop and a CPU access that land on the same index in the same cycle, with the line in exactly the state that changes the CPU outcome. An example is an Exclusive line that a snooped write miss invalidates just as the CPU reads it. Random traffic covers this poorly when addresses are spread out. The random stimulus therefore draws tags and indices from a few values each, so collisions, victim replacements and snoop matches happen often. Directed steps then build each such collision on purpose after putting the line in the needed state.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_RDMISS = 2'b01,
    OP_WRMISS = 2'b10
  } bus_op_e;
endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
  import coh_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  output logic [TAG_W-1:0] a_tag_o,
  output line_st_e         a_st_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [TAG_W-1:0] b_tag_o,
  output line_st_e         b_st_o,
  input  logic             snp_we_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  line_st_e         snp_st_i,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  logic [TAG_W-1:0] cpu_tag_i,
  input  line_st_e         cpu_st_i
);
  logic [TAG_W-1:0] tag_all [LINES];
  line_st_e         st_all  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [TAG_W-1:0] tag_q;
    line_st_e         st_q;
    logic             cpu_sel, snp_sel;
    assign cpu_sel = cpu_we_i && (cpu_idx_i == IDX_W'(g));
    assign snp_sel = snp_we_i && (snp_idx_i == IDX_W'(g));
    // cpu write already folds in a same-index snoop result
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        st_q  <= ST_INV;
      end else if (cpu_sel) begin
        tag_q <= cpu_tag_i;
        st_q  <= cpu_st_i;
      end else if (snp_sel) begin
        st_q  <= snp_st_i;
      end
    end
    assign tag_all[g] = tag_q;
    assign st_all[g]  = st_q;
  end

  assign a_tag_o = tag_all[a_idx_i];
  assign a_st_o  = st_all[a_idx_i];
  assign b_tag_o = tag_all[b_idx_i];
  assign b_st_o  = st_all[b_idx_i];
endmodule

// File: rtl/coh_snoop_ctl.sv
module coh_snoop_ctl
  import coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             valid_i,
  input  bus_op_e          op_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] cur_tag_i,
  input  line_st_e         cur_st_i,
  output logic             upd_o,
  output line_st_e         nxt_st_o,
  output logic             wb_o
);
  logic match;
  assign match = valid_i && (op_i != OP_NONE) && (cur_st_i != ST_INV) && (cur_tag_i == tag_i);

  always_comb begin
    upd_o    = 1'b0;
    wb_o     = 1'b0;
    nxt_st_o = cur_st_i;
    if (match) begin
      unique case (cur_st_i)
        ST_EXC: begin
          upd_o    = 1'b1;
          wb_o     = 1'b1;
          nxt_st_o = (op_i == OP_RDMISS) ? ST_SHR : ST_INV;
        end
        ST_SHR: begin
          if (op_i == OP_WRMISS) begin
            upd_o    = 1'b1;
            nxt_st_o = ST_INV;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/coh_cpu_ctl.sv
module coh_cpu_ctl
  import coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] cur_tag_i,
  input  line_st_e         cur_st_i,
  output logic             hit_o,
  output logic             miss_o,
  output bus_op_e          op_o,
  output logic             vic_wb_o,
  output logic [TAG_W-1:0] vic_tag_o,
  output logic             upd_o,
  output line_st_e         nxt_st_o
);
  logic present, enough;
  assign present = (cur_st_i != ST_INV) && (cur_tag_i == tag_i);
  assign enough  = we_i ? (cur_st_i == ST_EXC) : 1'b1;

  always_comb begin
    hit_o     = 1'b0;
    miss_o    = 1'b0;
    op_o      = OP_NONE;
    vic_wb_o  = 1'b0;
    vic_tag_o = cur_tag_i;
    upd_o     = 1'b0;
    nxt_st_o  = cur_st_i;
    if (req_i) begin
      if (present && enough) begin
        hit_o = 1'b1;
      end else begin
        miss_o   = 1'b1;
        upd_o    = 1'b1;
        op_o     = we_i ? OP_WRMISS : OP_RDMISS;
        nxt_st_o = we_i ? ST_EXC : ST_SHR;
        vic_wb_o = !present && (cur_st_i == ST_EXC);
      end
    end
  end
endmodule

// File: rtl/snoop_inval_ctrl.sv
module snoop_inval_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_hit_o,
  output logic              cpu_miss_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              vic_wb_o,
  output logic [ADDR_W-1:0] vic_addr_o,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_wb_o
);
  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0] s_cur_tag, c_cur_tag, vic_tag;
  line_st_e         s_cur_st, c_arr_st, c_cur_st, s_nxt_st, c_nxt_st;
  logic             s_upd, c_upd;
  bus_op_e          c_op;

  coh_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_idx_i   (snp_idx),
    .a_tag_o   (s_cur_tag),
    .a_st_o    (s_cur_st),
    .b_idx_i   (cpu_idx),
    .b_tag_o   (c_cur_tag),
    .b_st_o    (c_arr_st),
    .snp_we_i  (s_upd),
    .snp_idx_i (snp_idx),
    .snp_st_i  (s_nxt_st),
    .cpu_we_i  (c_upd),
    .cpu_idx_i (cpu_idx),
    .cpu_tag_i (cpu_tag),
    .cpu_st_i  (c_nxt_st)
  );

  coh_snoop_ctl #(.TAG_W(TAG_W)) i_snoop (
    .valid_i   (snp_valid_i),
    .op_i      (bus_op_e'(snp_op_i)),
    .tag_i     (snp_tag),
    .cur_tag_i (s_cur_tag),
    .cur_st_i  (s_cur_st),
    .upd_o     (s_upd),
    .nxt_st_o  (s_nxt_st),
    .wb_o      (snp_wb_o)
  );

  // snoop result seen by a same-index CPU access
  assign c_cur_st = (s_upd && (snp_idx == cpu_idx)) ? s_nxt_st : c_arr_st;

  coh_cpu_ctl #(.TAG_W(TAG_W)) i_cpu (
    .req_i     (cpu_req_i),
    .we_i      (cpu_we_i),
    .tag_i     (cpu_tag),
    .cur_tag_i (c_cur_tag),
    .cur_st_i  (c_cur_st),
    .hit_o     (cpu_hit_o),
    .miss_o    (cpu_miss_o),
    .op_o      (c_op),
    .vic_wb_o  (vic_wb_o),
    .vic_tag_o (vic_tag),
    .upd_o     (c_upd),
    .nxt_st_o  (c_nxt_st)
  );

  assign bus_op_o   = c_op;
  assign bus_addr_o = cpu_miss_o ? cpu_addr_i : '0;
  assign vic_addr_o = vic_wb_o ? {vic_tag, cpu_idx} : '0;
endmodule

// File: rtl/coh_ctl_checker.sv
module coh_ctl_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_hit_o,
  input logic              cpu_miss_o,
  input logic [1:0]        bus_op_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              vic_wb_o,
  input logic              snp_valid_i,
  input logic [1:0]        snp_op_i,
  input logic              snp_wb_o
);
  p_hit_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> (bus_op_o == 2'b00 && !cpu_miss_o && !vic_wb_o));

  p_read_miss_op_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && cpu_miss_o) |-> (bus_op_o == 2'b01 && bus_addr_o == cpu_addr_i));

  p_write_miss_op_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && cpu_miss_o) |-> (bus_op_o == 2'b10));

  p_victim_on_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_wb_o |-> (cpu_req_i && cpu_miss_o));

  p_snoop_wb_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_wb_o |-> (snp_valid_i && snp_op_i != 2'b00));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> (!cpu_hit_o && !cpu_miss_o && bus_op_o == 2'b00));

  p_refill_hits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cpu_req_i && cpu_miss_o) && cpu_req_i && !cpu_we_i
     && !snp_valid_i && cpu_addr_i == $past(cpu_addr_i)) |-> cpu_hit_o);
endmodule

bind snoop_inval_ctrl coh_ctl_checker #(.ADDR_W(ADDR_W)) i_coh_ctl_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_hit_o   (cpu_hit_o),
  .cpu_miss_o  (cpu_miss_o),
  .bus_op_o    (bus_op_o),
  .bus_addr_o  (bus_addr_o),
  .vic_wb_o    (vic_wb_o),
  .snp_valid_i (snp_valid_i),
  .snp_op_i    (snp_op_i),
  .snp_wb_o    (snp_wb_o)
);

// File: tb/test_snoop_inval_ctrl.sv
module test_snoop_inval_ctrl;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req_i = 1'b0, cpu_we_i = 1'b0, snp_valid_i = 1'b0;
  logic [ADDR_W-1:0] cpu_addr_i = '0, snp_addr_i = '0;
  logic [1:0] snp_op_i = 2'b00;
  logic cpu_hit_o, cpu_miss_o, vic_wb_o, snp_wb_o;
  logic [1:0] bus_op_o;
  logic [ADDR_W-1:0] bus_addr_o, vic_addr_o;

  always #2 clk = ~clk;

  snoop_inval_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_snoop_inval_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_hit_o(cpu_hit_o), .cpu_miss_o(cpu_miss_o),
    .bus_op_o(bus_op_o), .bus_addr_o(bus_addr_o),
    .vic_wb_o(vic_wb_o), .vic_addr_o(vic_addr_o),
    .snp_valid_i(snp_valid_i), .snp_op_i(snp_op_i), .snp_addr_i(snp_addr_i),
    .snp_wb_o(snp_wb_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model: 0 Invalid, 1 Shared, 2 Exclusive
  logic [TAG_W-1:0] m_tag [LINES];
  logic [1:0]       m_st  [LINES];

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
    return {TAG_W'(t), IDX_W'(i)};
  endfunction

  task automatic step(input logic req, input logic we, input logic [ADDR_W-1:0] a,
                      input logic sv, input logic [1:0] sop, input logic [ADDR_W-1:0] sa,
                      input string tag);
    logic e_hit, e_miss, e_vic, e_swb, pres;
    logic [1:0] e_op;
    logic [ADDR_W-1:0] e_vaddr, e_baddr;
    int si, ci;
    @(negedge clk);
    cpu_req_i = req; cpu_we_i = we; cpu_addr_i = a;
    snp_valid_i = sv; snp_op_i = sop; snp_addr_i = sa;
    #1;
    e_hit = 0; e_miss = 0; e_vic = 0; e_swb = 0; e_op = 2'b00;
    e_vaddr = '0; e_baddr = '0;
    si = int'(sa[IDX_W-1:0]);
    ci = int'(a[IDX_W-1:0]);
    if (sv && sop != 2'b00 && m_st[si] != 2'd0 && m_tag[si] == sa[ADDR_W-1:IDX_W]) begin
      if (m_st[si] == 2'd2) begin
        e_swb = 1;
        m_st[si] = (sop == 2'b01) ? 2'd1 : 2'd0;
      end else if (sop == 2'b10) m_st[si] = 2'd0;
    end
    if (req) begin
      pres = (m_st[ci] != 2'd0) && (m_tag[ci] == a[ADDR_W-1:IDX_W]);
      if (pres && (!we || m_st[ci] == 2'd2)) e_hit = 1;
      else begin
        e_miss = 1;
        e_op = we ? 2'b10 : 2'b01;
        e_baddr = a;
        if (!pres && m_st[ci] == 2'd2) begin
          e_vic = 1;
          e_vaddr = {m_tag[ci], IDX_W'(ci)};
        end
        m_tag[ci] = a[ADDR_W-1:IDX_W];
        m_st[ci] = we ? 2'd2 : 2'd1;
      end
    end
    checks++;
    if ({cpu_hit_o, cpu_miss_o, bus_op_o, vic_wb_o, snp_wb_o, bus_addr_o, vic_addr_o} !==
        {e_hit, e_miss, e_op, e_vic, e_swb, e_baddr, e_vaddr}) begin
      errors++;
      $display("FAIL %s: hit/miss/op/vic/swb/baddr/vaddr act %b %b %b %b %b %h %h exp %b %b %b %b %b %h %h",
               tag, cpu_hit_o, cpu_miss_o, bus_op_o, vic_wb_o, snp_wb_o, bus_addr_o, vic_addr_o,
               e_hit, e_miss, e_op, e_vic, e_swb, e_baddr, e_vaddr);
    end
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin m_tag[i] = '0; m_st[i] = 2'd0; end
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    checks++;
    if ({cpu_hit_o, cpu_miss_o, bus_op_o, vic_wb_o, snp_wb_o} !== 6'b0) begin
      errors++;
      $display("FAIL R1: reset outputs act %b exp 000000",
               {cpu_hit_o, cpu_miss_o, bus_op_o, vic_wb_o, snp_wb_o});
    end
    rst_ni = 1'b1;
    // directed
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R1 first read misses");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R2 re-read hits");
    step(1, 1, mk(1, 0), 0, 2'b00, '0, "R3 write on Shared");
    step(1, 1, mk(1, 0), 0, 2'b00, '0, "R4 write hit Exclusive");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R4 read hit Exclusive");
    step(0, 0, '0, 1, 2'b01, mk(1, 0), "R6 snoop read on Exclusive");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R6 line now Shared, read hit");
    step(1, 1, mk(1, 0), 0, 2'b00, '0, "R6 line Shared, write misses");
    step(0, 0, '0, 1, 2'b10, mk(1, 0), "R7 snoop write on Exclusive");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R7 line Invalid, read misses");
    step(0, 0, '0, 1, 2'b01, mk(1, 0), "R10 snoop read on Shared");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R10 Shared kept");
    step(0, 0, '0, 1, 2'b10, mk(1, 0), "R5 snoop write on Shared");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R5 line Invalid, read misses");
    step(1, 1, mk(1, 0), 0, 2'b00, '0, "R3 write to own Shared");
    step(0, 0, '0, 1, 2'b10, mk(2, 0), "R10 snoop tag mismatch");
    step(0, 0, '0, 1, 2'b00, mk(1, 0), "R10 snoop op none");
    step(1, 0, mk(2, 0), 0, 2'b00, '0, "R8 Exclusive victim");
    step(1, 0, mk(1, 0), 0, 2'b00, '0, "R8 Shared victim no write-back");
    step(1, 1, mk(1, 0), 0, 2'b00, '0, "R3 upgrade");
    step(1, 0, mk(1, 0), 1, 2'b10, mk(1, 0), "R9 snoop write then read");
    step(1, 1, mk(1, 0), 1, 2'b01, mk(1, 0), "R9 snoop read Shared then write");
    step(1, 0, mk(1, 0), 1, 2'b01, mk(1, 0), "R9 snoop read Exclusive then read hit");
    step(1, 1, mk(3, 0), 1, 2'b10, mk(1, 0), "R9 snoop then replace");
    // random traffic on few tags and indices
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 2));
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           mk($urandom_range(0, 2), $urandom_range(0, 3)),
           1'($urandom_range(0, 1)), op,
           mk($urandom_range(0, 2), $urandom_range(0, 3)), "R9 R10 random");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule